// File: doc/BRIEF.md
# Completion Event Ring Writer

This block turns completion reports from a transfer engine into 16-byte event records in a circular ring in system memory. The engine finishes descriptors in order and hands each result over as a 4-bit status code and a 4-bit error detail. The writer builds a record from that result and stores it as four 32-bit word writes at the current slot. It then moves its write pointer one slot forward and pulses an end-of-block interrupt request.

Software programs the ring base address as two 32-bit halves, plus the ring length in bytes. It reads the hardware write pointer to find new records. After consuming records it writes its own byte read offset to a doorbell, and that returns the space to the writer. When the next slot would collide with the read offset, the ring counts as full and further completions are held off.

Top module: `evt_ring_writer`

## Requirements
- R1: After reset the write pointer (read at 0x020) and doorbell offset (read at 0x400) are 0, the ring length (0x010) is the parameter DEF_LEN, mem_valid and eob_irq are low and cmp_ready is high.
- R2: Each accepted completion produces exactly four memory word writes at ring base + write pointer + 0, 4, 8 and 12, in that order; address and data hold steady while mem_ready is low.
- R3: The first word of a record holds the status code in bits 31:28 and the error detail in bits 27:24, with bits 23:0 zero; the other three words are zero. Code 1 means success and code 4 means failure.
- R4: The write pointer is a byte offset that is always a multiple of 16, advances by 16 once the last word of a record is accepted, and does not change otherwise.
- R5: When the advanced pointer reaches the ring length it wraps to 0.
- R6: The ring base is a 64-bit address whose low half is written at 0x008 and high half at 0x00C.
- R7: A write to the doorbell at 0x400 sets the read offset; its low four bits are ignored and read back as zero.
- R8: The ring is full when the write pointer advanced by 16 (with wrap) equals the read offset; while full, or while a record is being written, cmp_ready is low and no completion is taken.
- R9: eob_irq is a single-cycle pulse in the cycle after the last word of a record is accepted by memory.
- R10: Records land in consecutive slots in the order the completions were accepted.
- R11: A write to the ring length register (low four bits ignored) also clears the write pointer and the read offset to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 12 | Register byte address for write and read |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data for cfg_addr |
| cmp_valid | input | 1 | Completion report present |
| cmp_ready | output | 1 | Completion report taken this cycle |
| cmp_code | input | 4 | Completion status code |
| cmp_info | input | 4 | Completion error detail |
| mem_valid | output | 1 | Memory word write request |
| mem_ready | input | 1 | Memory accepts the word |
| mem_addr | output | ADDR_W | Byte address of the word |
| mem_wdata | output | 32 | Word data |
| eob_irq | output | 1 | End-of-block interrupt pulse |

## Verification
The assertions check on every cycle that a stalled memory write holds its address and data, that an accepted completion starts a write on the next cycle, and that the write pointer stays 16-byte aligned and below the ring length. They also check that the pointer moves only on record completion or a length write, that a full ring never shows cmp_ready, and that eob_irq never lasts two cycles. Only the bench scenarios can show the record layout and code ordering in memory, the slot addresses built from both base halves, and the wrap point. The same holds for full-ring blocking and release through the doorbell, the doorbell masking, and the pointer clear on a length write.

// File: rtl/evr_pkg.sv
package evr_pkg;
    localparam int REC_BYTES  = 16;
    localparam int WORD_BYTES = 4;
    localparam int WORD_W     = 32;
    localparam int REC_WORDS  = REC_BYTES / WORD_BYTES;
    localparam int REC_SHIFT  = $clog2(REC_BYTES);
    localparam int WB_SHIFT   = $clog2(WORD_BYTES);
    localparam int FIELD_W    = 4;
    localparam int CODE_LSB   = 28;
    localparam int INFO_LSB   = 24;
    localparam int CFG_AW     = 12;

    localparam logic [CFG_AW-1:0] RA_BASE_LO = 12'h008;
    localparam logic [CFG_AW-1:0] RA_BASE_HI = 12'h00C;
    localparam logic [CFG_AW-1:0] RA_LEN     = 12'h010;
    localparam logic [CFG_AW-1:0] RA_WPTR    = 12'h020;
    localparam logic [CFG_AW-1:0] RA_DBELL   = 12'h400;

    localparam logic [FIELD_W-1:0] ST_DONE = 4'd1;
    localparam logic [FIELD_W-1:0] ST_FAIL = 4'd4;
endpackage

// File: rtl/evr_regs.sv
module evr_regs
    import evr_pkg::*;
#(
    parameter int ADDR_W  = 64,
    parameter int OFF_W   = 16,
    parameter int DEF_LEN = 128
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cfg_we,
    input  logic [CFG_AW-1:0]   cfg_addr,
    input  logic [WORD_W-1:0]   cfg_wdata,
    input  logic [OFF_W-1:0]    wptr,
    output logic [WORD_W-1:0]   cfg_rdata,
    output logic [ADDR_W-1:0]   ring_base,
    output logic [OFF_W-1:0]    ring_len,
    output logic [OFF_W-1:0]    rd_off,
    output logic                len_wr
);
    localparam int HI_W = ADDR_W - WORD_W;

    typedef struct packed {
        logic [WORD_W-1:0] base_lo;
        logic [HI_W-1:0]   base_hi;
        logic [OFF_W-1:0]  len;
        logic [OFF_W-1:0]  rd;
    } regs_t;

    regs_t st_d, st_q;
    logic [OFF_W-1:0] wr_aligned;

    always_comb begin
        wr_aligned = {cfg_wdata[OFF_W-1:REC_SHIFT], {REC_SHIFT{1'b0}}};
        st_d       = st_q;
        len_wr     = 1'b0;
        if (cfg_we) begin
            unique case (cfg_addr)
                RA_BASE_LO: st_d.base_lo = cfg_wdata;
                RA_BASE_HI: st_d.base_hi = cfg_wdata[HI_W-1:0];
                RA_LEN: begin
                    st_d.len = wr_aligned;
                    st_d.rd  = '0;
                    len_wr   = 1'b1;
                end
                RA_DBELL:   st_d.rd = wr_aligned;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.base_lo <= '0;
            st_q.base_hi <= '0;
            st_q.len     <= OFF_W'(DEF_LEN);
            st_q.rd      <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        cfg_rdata = '0;
        unique case (cfg_addr)
            RA_BASE_LO: cfg_rdata = st_q.base_lo;
            RA_BASE_HI: cfg_rdata = WORD_W'(st_q.base_hi);
            RA_LEN:     cfg_rdata = WORD_W'(st_q.len);
            RA_WPTR:    cfg_rdata = WORD_W'(wptr);
            RA_DBELL:   cfg_rdata = WORD_W'(st_q.rd);
            default:    cfg_rdata = '0;
        endcase
    end

    assign ring_base = {st_q.base_hi, st_q.base_lo};
    assign ring_len  = st_q.len;
    assign rd_off    = st_q.rd;

    // R7
    dbell_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_off[REC_SHIFT-1:0] == '0);
endmodule

// File: rtl/evr_ptr.sv
module evr_ptr
    import evr_pkg::*;
#(
    parameter int OFF_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [OFF_W-1:0] ring_len,
    input  logic [OFF_W-1:0] rd_off,
    input  logic             len_wr,
    input  logic             advance,
    output logic [OFF_W-1:0] wptr,
    output logic             ring_full
);
    typedef struct packed {
        logic [OFF_W-1:0] wp;
    } ptr_t;

    ptr_t st_d, st_q;
    logic [OFF_W:0]   sum;
    logic [OFF_W-1:0] next_wp;

    always_comb begin
        sum     = {1'b0, st_q.wp} + (OFF_W+1)'(REC_BYTES);
        next_wp = (sum >= {1'b0, ring_len}) ? '0 : sum[OFF_W-1:0];
        st_d    = st_q;
        if (len_wr) begin
            st_d.wp = '0;
        end else if (advance) begin
            st_d.wp = next_wp;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.wp <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign wptr      = st_q.wp;
    assign ring_full = (next_wp == rd_off);

    // R4
    wp_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wptr[REC_SHIFT-1:0] == '0);
    // R4
    wp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!advance && !len_wr) |=> $stable(wptr));
    // R5
    wp_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ring_len != '0) |-> (wptr < ring_len));
endmodule

// File: rtl/evr_emit.sv
module evr_emit
    import evr_pkg::*;
#(
    parameter int ADDR_W = 64,
    parameter int OFF_W  = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cmp_valid,
    input  logic [FIELD_W-1:0]  cmp_code,
    input  logic [FIELD_W-1:0]  cmp_info,
    input  logic                ring_full,
    input  logic [ADDR_W-1:0]   ring_base,
    input  logic [OFF_W-1:0]    wptr,
    input  logic                mem_ready,
    output logic                cmp_ready,
    output logic                mem_valid,
    output logic [ADDR_W-1:0]   mem_addr,
    output logic [WORD_W-1:0]   mem_wdata,
    output logic                rec_done,
    output logic                eob_irq
);
    localparam int IDX_W = $clog2(REC_WORDS);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(REC_WORDS - 1);

    typedef struct packed {
        logic               busy;
        logic [IDX_W-1:0]   idx;
        logic [FIELD_W-1:0] code;
        logic [FIELD_W-1:0] info;
        logic               irq;
    } emit_t;

    emit_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.irq = 1'b0;
        rec_done = 1'b0;
        if (!st_q.busy) begin
            if (cmp_valid && !ring_full) begin
                st_d.busy = 1'b1;
                st_d.idx  = '0;
                st_d.code = cmp_code;
                st_d.info = cmp_info;
            end
        end else if (mem_ready) begin
            if (st_q.idx == LAST_IDX) begin
                st_d.busy = 1'b0;
                st_d.irq  = 1'b1;
                rec_done  = 1'b1;
            end else begin
                st_d.idx = st_q.idx + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        mem_wdata = '0;
        if (st_q.idx == '0) begin
            mem_wdata[CODE_LSB +: FIELD_W] = st_q.code;
            mem_wdata[INFO_LSB +: FIELD_W] = st_q.info;
        end
        mem_addr = ring_base + ADDR_W'(wptr)
                 + (ADDR_W'(st_q.idx) << WB_SHIFT);
    end

    assign cmp_ready = !st_q.busy && !ring_full;
    assign mem_valid = st_q.busy;
    assign eob_irq   = st_q.irq;

    // R2
    hold_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr) && $stable(mem_wdata)));
    // R2
    accept_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_valid && cmp_ready) |=> mem_valid);
    // R9
    irq_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        eob_irq |=> !eob_irq);
    // R9
    irq_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        eob_irq |-> !mem_valid);
endmodule

// File: rtl/evt_ring_writer.sv
module evt_ring_writer
    import evr_pkg::*;
#(
    parameter int ADDR_W  = 64,
    parameter int OFF_W   = 16,
    parameter int DEF_LEN = 128
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_we,
    input  logic [11:0]        cfg_addr,
    input  logic [31:0]        cfg_wdata,
    output logic [31:0]        cfg_rdata,
    input  logic               cmp_valid,
    output logic               cmp_ready,
    input  logic [3:0]         cmp_code,
    input  logic [3:0]         cmp_info,
    output logic               mem_valid,
    input  logic               mem_ready,
    output logic [ADDR_W-1:0]  mem_addr,
    output logic [31:0]        mem_wdata,
    output logic               eob_irq
);
    logic [ADDR_W-1:0] ring_base;
    logic [OFF_W-1:0]  ring_len;
    logic [OFF_W-1:0]  rd_off;
    logic [OFF_W-1:0]  wptr;
    logic              len_wr;
    logic              ring_full;
    logic              rec_done;

    evr_regs #(.ADDR_W(ADDR_W), .OFF_W(OFF_W), .DEF_LEN(DEF_LEN)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_addr  (cfg_addr),
        .cfg_wdata (cfg_wdata),
        .wptr      (wptr),
        .cfg_rdata (cfg_rdata),
        .ring_base (ring_base),
        .ring_len  (ring_len),
        .rd_off    (rd_off),
        .len_wr    (len_wr)
    );

    evr_ptr #(.OFF_W(OFF_W)) u_ptr (
        .clk       (clk),
        .rst_n     (rst_n),
        .ring_len  (ring_len),
        .rd_off    (rd_off),
        .len_wr    (len_wr),
        .advance   (rec_done),
        .wptr      (wptr),
        .ring_full (ring_full)
    );

    evr_emit #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_emit (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmp_valid (cmp_valid),
        .cmp_code  (cmp_code),
        .cmp_info  (cmp_info),
        .ring_full (ring_full),
        .ring_base (ring_base),
        .wptr      (wptr),
        .mem_ready (mem_ready),
        .cmp_ready (cmp_ready),
        .mem_valid (mem_valid),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .rec_done  (rec_done),
        .eob_irq   (eob_irq)
    );

    // R8
    full_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ring_full |-> !cmp_ready);
endmodule

// File: tb/sim_evt_ring_writer.sv
`timescale 1ns/1ps
module sim_evt_ring_writer;
    localparam int NV = 10;
    localparam logic [7:0] VEC [NV] = '{8'h10, 8'h4F, 8'h10, 8'h43, 8'h1A,
                                        8'h40, 8'h10, 8'h17, 8'h4C, 8'h15};
    localparam logic [63:0] BASE = 64'h0000_0002_1000_0000;

    logic        clk = 0;
    logic        rst_n = 0;
    logic        cfg_we = 0;
    logic [11:0] cfg_addr = 0;
    logic [31:0] cfg_wdata = 0;
    logic [31:0] cfg_rdata;
    logic        cmp_valid = 0;
    logic        cmp_ready;
    logic [3:0]  cmp_code = 0;
    logic [3:0]  cmp_info = 0;
    logic        mem_valid;
    logic        mem_ready = 1;
    logic [63:0] mem_addr;
    logic [31:0] mem_wdata;
    logic        eob_irq;

    int total = 0;
    int bad = 0;
    int cap_n = 0;
    int irq_cnt = 0;
    logic [63:0] cap_addr [256];
    logic [31:0] cap_data [256];
    logic        stall_en = 0;
    logic [4:0]  lfsr = 5'h1B;
    int mwp = 0;
    int mlen = 128;
    bit done = 0;

    always #2 clk = ~clk;

    evt_ring_writer u0 (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .cmp_valid(cmp_valid),
        .cmp_ready(cmp_ready), .cmp_code(cmp_code), .cmp_info(cmp_info),
        .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .eob_irq(eob_irq)
    );

    always @(posedge clk) begin
        #1;
        lfsr <= {lfsr[3:0], lfsr[4] ^ lfsr[2]};
        mem_ready <= stall_en ? lfsr[0] : 1'b1;
    end

    always @(negedge clk) begin
        if (mem_valid && mem_ready && cap_n < 256) begin
            cap_addr[cap_n] = mem_addr;
            cap_data[cap_n] = mem_wdata;
            cap_n = cap_n + 1;
        end
        if (eob_irq) irq_cnt = irq_cnt + 1;
    end

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        cfg_addr = a; cfg_wdata = d; cfg_we = 1;
        @(negedge clk);
        cfg_we = 0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        cfg_addr = a;
        #1;
        d = cfg_rdata;
    endtask

    task automatic send(input logic [3:0] c, input logic [3:0] i);
        @(negedge clk);
        cmp_valid = 1; cmp_code = c; cmp_info = i;
        while (!cmp_ready) @(negedge clk);
        @(negedge clk);
        cmp_valid = 0;
    endtask

    task automatic do_rec(input logic [3:0] c, input logic [3:0] i);
        int s0, ic;
        logic [31:0] v, w0;
        s0 = cap_n; ic = irq_cnt;
        send(c, i);
        while (irq_cnt == ic) @(negedge clk);
        repeat (2) @(negedge clk);
        chk(irq_cnt == ic + 1, "R9 one pulse per record", irq_cnt - ic, 1);
        chk(cap_n - s0 == 4, "R2 four words", cap_n - s0, 4);
        w0 = {c, i, 24'h0};
        for (int k = 0; k < 4; k++) begin
            chk(cap_addr[s0+k] == BASE + 64'(mwp) + 64'(4*k), "R2/R6/R10 word address",
                cap_addr[s0+k], BASE + 64'(mwp) + 64'(4*k));
            chk(cap_data[s0+k] == ((k == 0) ? w0 : 32'h0), "R3/R10 word data",
                cap_data[s0+k], (k == 0) ? w0 : 32'h0);
        end
        mwp = (mwp + 16 >= mlen) ? 0 : mwp + 16;
        rd(12'h020, v);
        chk(v == 32'(mwp), "R4/R5 write pointer", v, mwp);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        #(4ns * 150000);
        total++; bad++;
        $display("FAIL watchdog act=timeout exp=finish");
        finish_run();
    end

    initial begin
        logic [31:0] v;
        int s0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        rd(12'h020, v); chk(v == 0, "R1 wptr", v, 0);
        rd(12'h400, v); chk(v == 0, "R1 doorbell", v, 0);
        rd(12'h010, v); chk(v == 128, "R1 length", v, 128);
        chk(!mem_valid && !eob_irq && cmp_ready, "R1 outputs",
            {mem_valid, eob_irq, cmp_ready}, 3'b001);

        wr(12'h008, BASE[31:0]);
        wr(12'h00C, BASE[63:32]);
        rd(12'h00C, v); chk(v == BASE[63:32], "R6 base high", v, BASE[63:32]);

        // vector walk: R2 R3 R4 R5 R10, doorbell consumed after each record
        for (int n = 0; n < NV; n++) begin
            stall_en = n[0];
            do_rec(VEC[n][7:4], VEC[n][3:0]);
            wr(12'h400, 32'(mwp));
        end
        stall_en = 0;

        // R8 fill the ring: capacity is len/16 - 1 records
        for (int n = 0; n < 7; n++) do_rec(4'd1, 4'(n));
        s0 = cap_n;
        @(negedge clk);
        cmp_valid = 1; cmp_code = 4'd4; cmp_info = 4'hE;
        repeat (8) begin
            @(negedge clk);
            chk(!cmp_ready, "R8 blocked when full", cmp_ready, 0);
        end
        cmp_valid = 0;
        chk(cap_n == s0, "R8 no write while full", cap_n - s0, 0);
        rd(12'h020, v); chk(v == 32'(mwp), "R8 wptr unchanged while full", v, mwp);
        wr(12'h400, 32'(mwp));
        chk(cmp_ready, "R8 released by doorbell", cmp_ready, 1);
        do_rec(4'd4, 4'hE);

        // R7 doorbell low bits ignored
        wr(12'h400, 32'h25);
        rd(12'h400, v); chk(v == 32'h20, "R7 doorbell mask", v, 32'h20);

        // R11 length write clears pointers
        wr(12'h010, 32'h4B);
        mlen = 64; mwp = 0;
        rd(12'h010, v); chk(v == 64, "R11 length mask", v, 64);
        rd(12'h020, v); chk(v == 0, "R11 wptr cleared", v, 0);
        rd(12'h400, v); chk(v == 0, "R11 doorbell cleared", v, 0);
        for (int n = 0; n < 3; n++) do_rec(4'd1, 4'(n + 8));
        @(negedge clk);
        chk(!cmp_ready, "R8/R5 full at short length", cmp_ready, 0);
        wr(12'h400, 32'd48);
        do_rec(4'd1, 4'h9);
        chk(mwp == 0, "R5 wrap at 64", mwp, 0);

        finish_run();
    end
endmodule